// File: doc/BRIEF.md
# Time-Triggered Timestamp Capture Unit

This block keeps a free-running bit-time counter for time-triggered CAN operation. While the time-triggered mode is enabled, the counter advances by one on every nominal bit-time tick. When the mode is off, the counter is forced to zero and stays there. A strobe marks the sample point of a Start-Of-Frame bit, and a direction flag says whether the frame is being received or transmitted. At that strobe the block latches the counter into the timestamp register for that direction. Each register is read out as a high byte and a low byte.

For an outgoing frame, the block can also insert global time into the payload. When global-time transmission is requested, the transmit timestamp bytes overwrite the last two data bytes that the frame's data length code covers. The block does not produce framing bits or a CRC. It takes a payload in and returns the patched payload.

Top module: `tt_stamp_unit`

## Requirements
- R1: While `tt_en` is low, the counter is zero one cycle later and stays zero whatever `bit_tick` does. A capture made in that state stores 0x0000.
- R2: While `tt_en` is high, the counter rises by exactly one for each cycle in which `bit_tick` is high. It does not move in cycles where `bit_tick` is low.
- R3: The counter is 16 bits wide and steps from 0xFFFF to 0x0000 on the next tick.
- R4: When `sof_strobe` is high at a clock edge, the counter value is stored in the transmit register if `sof_is_tx` is 1, or in the receive register if it is 0. The stored value appears on the outputs in the following cycle.
- R5: If a capture strobe and a tick arrive in the same cycle, the register stores the counter value from before that increment.
- R6: A timestamp register keeps its value until the next strobe for its own direction. A strobe for the other direction leaves it unchanged.
- R7: The `*_hi` output carries bits 15:8 of the stored value and the `*_lo` output carries bits 7:0.
- R8: Data byte k sits at `tx_payload_in[8k+7:8k]`. When `tgt_req` is 1 and the effective length L is 2 or more, output byte L-2 takes `tx_stamp_hi` and byte L-1 takes `tx_stamp_lo`. The change appears in the same cycle, with no register in the path.
- R9: A `tx_dlc` value from 9 to 15 is treated as an effective length of 8.
- R10: When `tgt_req` is 0 or the effective length is below 2, `tx_payload_out` equals `tx_payload_in`. Bytes other than L-2 and L-1 always pass through unchanged.
- R11: After reset, both timestamp registers and the counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tt_en | input | 1 | Time-triggered mode enable |
| bit_tick | input | 1 | One-cycle pulse per nominal bit time |
| sof_strobe | input | 1 | Start-Of-Frame sample-point strobe |
| sof_is_tx | input | 1 | Strobe direction: 1 transmit, 0 receive |
| tx_dlc | input | 4 | Data length code of the outgoing frame |
| tx_payload_in | input | 64 | Outgoing payload, byte k at bits 8k+7:8k |
| tgt_req | input | 1 | Request to insert global time into the payload |
| rx_stamp_hi | output | 8 | Receive timestamp, high byte |
| rx_stamp_lo | output | 8 | Receive timestamp, low byte |
| tx_stamp_hi | output | 8 | Transmit timestamp, high byte |
| tx_stamp_lo | output | 8 | Transmit timestamp, low byte |
| tx_payload_out | output | 64 | Payload after timestamp insertion |

## Verification
Timestamp outputs change one edge after a strobe, because one register sits between the strobe and the output. The counter changes one edge after a tick or after a change of enable. The bench therefore drives each stimulus on a falling edge, lets exactly one rising edge pass, and reads the timestamp outputs on the next falling edge. Counter values can only be seen through captures, so every counter expectation is read from a strobe issued after a known number of tick cycles. The payload path has no register, so its vectors are checked one nanosecond after the inputs are applied, in the same cycle.

// File: rtl/tt_stamp_pkg.sv
package tt_stamp_pkg;
    localparam int BYTE_W      = 8;
    localparam int STAMP_BYTES = 2;
    localparam int STAMP_W     = BYTE_W * STAMP_BYTES;
    localparam int DIR_CNT     = 2;   // index 0 receive, 1 transmit
    localparam int DIR_RX      = 0;
    localparam int DIR_TX      = 1;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef struct packed {
        stamp_t cnt;
    } base_state_t;

    typedef struct packed {
        stamp_t value;
    } cap_state_t;
endpackage

// File: rtl/tt_time_base.sv
module tt_time_base
    import tt_stamp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   tick,
    output stamp_t count
);
    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + stamp_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> count == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && count != '1) |=> count == $past(count) + stamp_t'(1));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(count));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && count == '1) |=> count == '0);
endmodule

// File: rtl/tt_capture_reg.sv
module tt_capture_reg
    import tt_stamp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  stamp_t sample,
    output stamp_t stamp
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.value = sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp = st_q.value;

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> stamp == $past(sample));

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(stamp));
endmodule

// File: rtl/tt_payload_patch.sv
module tt_payload_patch
    import tt_stamp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int DLC_W     = 4,
    localparam int PAY_W    = MAX_BYTES * BYTE_W
) (
    input  logic [DLC_W-1:0] dlc,
    input  logic             insert,
    input  stamp_t           stamp,
    input  logic [PAY_W-1:0] pay_in,
    output logic [PAY_W-1:0] pay_out
);
    logic [DLC_W-1:0] eff_len;
    logic             active;
    logic [DLC_W-1:0] hi_idx, lo_idx;

    always_comb begin
        eff_len = (dlc > DLC_W'(MAX_BYTES)) ? DLC_W'(MAX_BYTES) : dlc;
        active  = insert && (eff_len >= DLC_W'(STAMP_BYTES));
        hi_idx  = eff_len - DLC_W'(2);
        lo_idx  = eff_len - DLC_W'(1);
        pay_out = pay_in;
        for (int k = 0; k < MAX_BYTES; k++) begin
            if (active && DLC_W'(k) == hi_idx) begin
                pay_out[k*BYTE_W +: BYTE_W] = stamp[STAMP_W-1 -: BYTE_W];
            end else if (active && DLC_W'(k) == lo_idx) begin
                pay_out[k*BYTE_W +: BYTE_W] = stamp[BYTE_W-1:0];
            end
        end
    end

    always_comb begin
        if (!insert || dlc < DLC_W'(STAMP_BYTES)) begin
            p_pass_r10: assert (pay_out == pay_in);
        end
    end
endmodule

// File: rtl/tt_stamp_unit.sv
module tt_stamp_unit
    import tt_stamp_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int DLC_W     = 4,
    localparam int PAY_W    = MAX_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tt_en,
    input  logic              bit_tick,
    input  logic              sof_strobe,
    input  logic              sof_is_tx,
    input  logic [DLC_W-1:0]  tx_dlc,
    input  logic [PAY_W-1:0]  tx_payload_in,
    input  logic              tgt_req,
    output logic [BYTE_W-1:0] rx_stamp_hi,
    output logic [BYTE_W-1:0] rx_stamp_lo,
    output logic [BYTE_W-1:0] tx_stamp_hi,
    output logic [BYTE_W-1:0] tx_stamp_lo,
    output logic [PAY_W-1:0]  tx_payload_out
);
    stamp_t count;
    stamp_t stamps [DIR_CNT];
    logic   load_v [DIR_CNT];

    tt_time_base u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (tt_en),
        .tick   (bit_tick),
        .count  (count)
    );

    for (genvar g = 0; g < DIR_CNT; g++) begin : g_dir
        assign load_v[g] = sof_strobe && ((g == DIR_TX) ? sof_is_tx : !sof_is_tx);

        tt_capture_reg u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load_v[g]),
            .sample (count),
            .stamp  (stamps[g])
        );
    end

    assign rx_stamp_hi = stamps[DIR_RX][STAMP_W-1 -: BYTE_W];
    assign rx_stamp_lo = stamps[DIR_RX][BYTE_W-1:0];
    assign tx_stamp_hi = stamps[DIR_TX][STAMP_W-1 -: BYTE_W];
    assign tx_stamp_lo = stamps[DIR_TX][BYTE_W-1:0];

    tt_payload_patch #(
        .MAX_BYTES (MAX_BYTES),
        .DLC_W     (DLC_W)
    ) u_patch (
        .dlc     (tx_dlc),
        .insert  (tgt_req),
        .stamp   (stamps[DIR_TX]),
        .pay_in  (tx_payload_in),
        .pay_out (tx_payload_out)
    );

    p_rx_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_strobe && sof_is_tx) |=> $stable(stamps[DIR_RX]));

    p_tx_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_strobe && !sof_is_tx) |=> $stable(stamps[DIR_TX]));

    p_cap_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_strobe && bit_tick && tt_en) |=> stamps[sof_is_tx ? DIR_TX : DIR_RX] == $past(count));
endmodule

// File: tb/tb_tt_stamp_unit.sv
`timescale 1ns/1ps
module tb_tt_stamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tt_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        sof_strobe = 1'b0;
    logic        sof_is_tx = 1'b0;
    logic [3:0]  tx_dlc = 4'd0;
    logic [63:0] tx_payload_in = 64'h0;
    logic        tgt_req = 1'b0;
    logic [7:0]  rx_stamp_hi, rx_stamp_lo, tx_stamp_hi, tx_stamp_lo;
    logic [63:0] tx_payload_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tt_stamp_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tt_en          (tt_en),
        .bit_tick       (bit_tick),
        .sof_strobe     (sof_strobe),
        .sof_is_tx      (sof_is_tx),
        .tx_dlc         (tx_dlc),
        .tx_payload_in  (tx_payload_in),
        .tgt_req        (tgt_req),
        .rx_stamp_hi    (rx_stamp_hi),
        .rx_stamp_lo    (rx_stamp_lo),
        .tx_stamp_hi    (tx_stamp_hi),
        .tx_stamp_lo    (tx_stamp_lo),
        .tx_payload_out (tx_payload_out)
    );

    typedef struct packed {
        logic [3:0]  dlc;
        logic        tgt;
        logic [1:0]  kind;   // 0 insertion, 1 long code, 2 pass-through
        logic [63:0] expect_out;
    } vec_t;

    localparam logic [63:0] BASE = 64'h8877665544332211;
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'd8,  1'b1, 2'd0, 64'h2301665544332211},
        '{4'd8,  1'b0, 2'd2, 64'h8877665544332211},
        '{4'd2,  1'b1, 2'd0, 64'h8877665544332301},
        '{4'd1,  1'b1, 2'd2, 64'h8877665544332211},
        '{4'd0,  1'b1, 2'd2, 64'h8877665544332211},
        '{4'd5,  1'b1, 2'd0, 64'h8877662301332211},
        '{4'd12, 1'b1, 2'd1, 64'h2301665544332211},
        '{4'd15, 1'b1, 2'd1, 64'h2301665544332211}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic tick_n(input int n);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic strobe(input logic is_tx);
        sof_strobe = 1'b1;
        sof_is_tx  = is_tx;
        @(negedge clk);
        sof_strobe = 1'b0;
    endtask

    function automatic logic [63:0] rx16();
        return {48'h0, rx_stamp_hi, rx_stamp_lo};
    endfunction

    function automatic logic [63:0] tx16();
        return {48'h0, tx_stamp_hi, tx_stamp_lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 rx stamp", rx16(), 64'h0);
        check("R11 tx stamp", tx16(), 64'h0);
        tx_payload_in = BASE;
        #1 check("R11 payload passthrough", tx_payload_out, BASE);

        // R2 R4: count 0x123 ticks, capture transmit
        tt_en = 1'b1;
        @(negedge clk);
        tick_n(16'h0123);
        strobe(1'b1);
        check("R4 tx capture", tx16(), 64'h0123);
        check("R7 tx byte split", {56'h0, tx_stamp_hi}, 64'h01);
        check("R6 rx untouched by tx strobe", rx16(), 64'h0);

        // R8 R9 R10: vector table
        for (int i = 0; i < NVEC; i++) begin
            tx_dlc  = VECS[i].dlc;
            tgt_req = VECS[i].tgt;
            #1;
            case (VECS[i].kind)
                2'd0:    check("R8 insertion", tx_payload_out, VECS[i].expect_out);
                2'd1:    check("R9 long code", tx_payload_out, VECS[i].expect_out);
                default: check("R10 passthrough", tx_payload_out, VECS[i].expect_out);
            endcase
            @(negedge clk);
        end
        tgt_req = 1'b0;

        // R2: no tick, counter idle
        repeat (10) @(negedge clk);
        strobe(1'b1);
        check("R2 idle without tick", tx16(), 64'h0123);

        // R5: tick and strobe together
        bit_tick   = 1'b1;
        sof_strobe = 1'b1;
        sof_is_tx  = 1'b0;
        @(negedge clk);
        bit_tick   = 1'b0;
        sof_strobe = 1'b0;
        check("R5 pre-increment value", rx16(), 64'h0123);
        strobe(1'b0);
        check("R2 single increment", rx16(), 64'h0124);
        check("R6 tx held", tx16(), 64'h0123);

        // R1: disabled counter stays zero
        tt_en = 1'b0;
        @(negedge clk);
        tick_n(5);
        strobe(1'b0);
        check("R1 zero while disabled", rx16(), 64'h0);
        check("R6 tx held over disable", tx16(), 64'h0123);

        // R3: wrap
        tt_en = 1'b1;
        @(negedge clk);
        tick_n(65535);
        strobe(1'b1);
        check("R3 reaches max", tx16(), 64'hFFFF);
        check("R7 tx low byte", {56'h0, tx_stamp_lo}, 64'hFF);
        tick_n(1);
        strobe(1'b1);
        check("R3 wraps to zero", tx16(), 64'h0);
        tx_dlc  = 4'd8;
        tgt_req = 1'b1;
        #1 check("R8 insertion of zero stamp", tx_payload_out, 64'h0000665544332211);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule